// File: doc/BRIEF.md
# Indirect Configuration Space Access Port

This block lets a CPU register bus reach the configuration registers of devices behind a host bridge through two small ports. The first port is a 32-bit latch holding an enable bit and a target address (bus number, device/function number, byte offset). The second port is a data window: each access to it is turned into configuration traffic on a simple downstream interface, addressed by the latch merged with the low two bits of the window access.

For every window access the block gates on the enable bit and checks the byte offset against the configured space limit. It then asks the downstream side whether the target exists. A function that was hot-added and is not function 0 triggers a second lookup of function 0 of the same device; if that one is absent, the function stays hidden. Only then does the block issue the read or write, with the byte length clipped at the space limit. Every read that is dropped returns all ones.

The sequencer has five states. ST_IDLE accepts requests. ST_PROBE looks up the target. ST_PROBE_F0 looks up function 0. ST_ACCESS performs the read or write. ST_RESP returns read data. The transitions are:
- ST_IDLE→ST_RESP on an address-port read, or on a window read that is disabled or out of range.
- ST_IDLE→ST_PROBE on a window access that passes both checks.
- ST_PROBE→ST_PROBE_F0 when the lookup reports a hot-added function with a non-zero function number.
- ST_PROBE→ST_ACCESS when the target is present and needs no check of function 0.
- ST_PROBE_F0→ST_ACCESS when function 0 is present.
- Either lookup state goes to ST_RESP (read) or ST_IDLE (write) when the target or function 0 is absent.
- ST_ACCESS goes to ST_RESP (read) or ST_IDLE (write) on acknowledge.
- ST_RESP→ST_IDLE always.

Top module: `cfg_access_port`

## Requirements
- R1: After reset the latched address is 0, cpu_rdy is 1, and dn_req and cpu_rvalid are 0.
- R2: A write with cpu_sel=0 updates the latch only when cpu_addr=0 and cpu_size=4. Any other address-port write leaves the latch unchanged.
- R3: A read with cpu_sel=0 returns all 32 latched bits, including bits 30:24, for any size or byte address. cpu_rvalid pulses in the cycle after acceptance.
- R4: When latch bit 31 is 0, a window read (cpu_sel=1) returns 0xFFFFFFFF and a window write causes no downstream request.
- R5: The effective address is the latch ORed with cpu_addr. dn_bus carries bits 23:16, dn_devfn bits 15:8 and dn_off bits 7:0.
- R6: A window access issues a lookup (dn_op=0), then a read (dn_op=1) or a write (dn_op=2). dn_req and its fields stay stable until dn_ack.
- R7: If a lookup answers dn_found=0, a read returns 0xFFFFFFFF and a write issues no access.
- R8: An offset at or above SPACE_LIMIT is dropped with no downstream request: reads return 0xFFFFFFFF.
- R9: dn_len is the minimum of cpu_size (capped at 4) and SPACE_LIMIT minus the offset.
- R10: A lookup with dn_hotadd=1 and dn_devfn[2:0]≠0 is followed by a lookup of devfn with bits 2:0 cleared. If that lookup answers not found, the access is hidden (reads give all ones, writes are ignored). A hot-added function 0 gets a single lookup.
- R11: Data read downstream is returned unchanged with a one-cycle cpu_rvalid pulse. cpu_rdy stays 0 from acceptance until the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | CPU request, accepted when cpu_rdy is high |
| cpu_rdy | output | 1 | Block idle, can accept a request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | 1 | 0 = address latch port, 1 = data window |
| cpu_addr | input | 2 | Byte address within the port |
| cpu_size | input | 3 | Access size in bytes (1, 2 or 4) |
| cpu_wdata | input | 32 | Write data |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 32 | Read data |
| dn_req | output | 1 | Downstream request, held until dn_ack |
| dn_op | output | 2 | 0 lookup, 1 read, 2 write |
| dn_bus | output | 8 | Bus number |
| dn_devfn | output | 8 | Device/function number |
| dn_off | output | 8 | Byte offset |
| dn_len | output | 3 | Byte length (0 on lookups) |
| dn_wdata | output | 32 | Write data |
| dn_ack | input | 1 | Downstream completion strobe |
| dn_found | input | 1 | Lookup result: target exists |
| dn_hotadd | input | 1 | Lookup result: target was hot-added |
| dn_rdata | input | 32 | Read data on a read acknowledge |

## Verification
Two functions meet in a single window access: the merge of the window's byte address into the latched offset, and the range check with length clipping. The clip must use the merged offset, not the latched one. The bench provokes this with a latched offset just below the limit and a non-zero window byte address, then checks dn_len and the data against values computed from the merged offset. The hot-add check of function 0 is also combined with clipped accesses in random traffic, where the lookup count and the final request fields are compared with the bench's model of present and hot-added targets.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_PROBE_F0,
        ST_ACCESS,
        ST_RESP
    } seq_state_t;

    localparam logic [1:0] OP_LOOKUP = 2'd0;
    localparam logic [1:0] OP_READ   = 2'd1;
    localparam logic [1:0] OP_WRITE  = 2'd2;

    localparam logic [WORD_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [7:0] bus;
        logic [7:0] devfn;
        logic [7:0] off;
    } cfg_target_t;

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_off,
    input  logic [2:0]       wr_size,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);
    localparam logic [2:0] FULL_BYTES = 3'(WIDTH / 8);

    logic take;
    assign take = wr_en && (wr_off == 2'd0) && (wr_size == FULL_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (take) q <= wr_data;
    end

    // R2: partial or misaligned writes leave the latch unchanged
    a_r2_drop_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_off != 2'd0 || wr_size != FULL_BYTES)) |=> $stable(q));

    // R2: a full aligned write is taken as is
    a_r2_take_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == 2'd0 && wr_size == FULL_BYTES) |=> (q == $past(wr_data)));
endmodule

// File: rtl/cfg_window_calc.sv
module cfg_window_calc
    import cfgp_pkg::*;
#(
    parameter int unsigned SPACE_LIMIT = 256
) (
    input  logic [WORD_W-1:0] latch_q,
    input  logic [1:0]        win_addr,
    input  logic [2:0]        req_size,
    output cfg_target_t       tgt,
    output logic              enabled,
    output logic              in_range,
    output logic [2:0]        len
);
    localparam int unsigned LIM_W = 9;
    localparam logic [LIM_W-1:0] LIM_V = LIM_W'(SPACE_LIMIT);
    localparam logic [2:0] MAX_LEN = 3'd4;

    logic [WORD_W-1:0] eff;
    logic [LIM_W-1:0]  rem;
    logic [2:0]        want;

    always_comb begin
        eff       = latch_q | {{(WORD_W-2){1'b0}}, win_addr};
        tgt.bus   = eff[23:16];
        tgt.devfn = eff[15:8];
        tgt.off   = eff[7:0];
        enabled   = latch_q[WORD_W-1];
        in_range  = {1'b0, tgt.off} < LIM_V;
        rem       = LIM_V - {1'b0, tgt.off};
        want      = (req_size > MAX_LEN) ? MAX_LEN : req_size;
        len       = (rem < {6'd0, want}) ? rem[2:0] : want;
    end
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_sel,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [WORD_W-1:0] latch_q,
    input  cfg_target_t       tgt,
    input  logic              enabled,
    input  logic              in_range,
    input  logic [2:0]        len,
    output logic              cpu_rdy,
    output logic              cpu_rvalid,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              latch_wr,
    output logic              dn_req,
    output logic [1:0]        dn_op,
    output logic [7:0]        dn_bus,
    output logic [7:0]        dn_devfn,
    output logic [7:0]        dn_off,
    output logic [2:0]        dn_len,
    output logic [WORD_W-1:0] dn_wdata,
    input  logic              dn_ack,
    input  logic              dn_found,
    input  logic              dn_hotadd,
    input  logic [WORD_W-1:0] dn_rdata
);
    seq_state_t        state, nxt;
    cfg_target_t       tgt_q;
    logic [2:0]        len_q;
    logic              we_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic              accept;
    logic              win_ok;
    logic              nonzero_fn;
    seq_state_t        drop_to;

    assign accept     = cpu_req && (state == ST_IDLE);
    assign win_ok     = enabled && in_range;
    assign nonzero_fn = (tgt_q.devfn[2:0] != 3'd0);
    assign drop_to    = we_q ? ST_IDLE : ST_RESP;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!cpu_sel)     nxt = cpu_we ? ST_IDLE : ST_RESP;
                    else if (!win_ok) nxt = cpu_we ? ST_IDLE : ST_RESP;
                    else              nxt = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (dn_ack) begin
                    if (!dn_found)                   nxt = drop_to;
                    else if (dn_hotadd && nonzero_fn) nxt = ST_PROBE_F0;
                    else                             nxt = ST_ACCESS;
                end
            end
            ST_PROBE_F0: begin
                if (dn_ack) nxt = dn_found ? ST_ACCESS : drop_to;
            end
            ST_ACCESS: begin
                if (dn_ack) nxt = drop_to;
            end
            ST_RESP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tgt_q   <= '0;
            len_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        tgt_q   <= tgt;
                        len_q   <= len;
                        we_q    <= cpu_we;
                        wdata_q <= cpu_wdata;
                        if (!cpu_sel)    rdata_q <= latch_q;
                        else if (!win_ok) rdata_q <= ALL_ONES;
                    end
                end
                ST_PROBE, ST_PROBE_F0: begin
                    if (dn_ack && !dn_found) rdata_q <= ALL_ONES;
                end
                ST_ACCESS: begin
                    if (dn_ack && !we_q) rdata_q <= dn_rdata;
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cpu_rdy    = 1'b0;
        cpu_rvalid = 1'b0;
        cpu_rdata  = '0;
        latch_wr   = 1'b0;
        dn_req     = 1'b0;
        dn_op      = OP_LOOKUP;
        dn_bus     = tgt_q.bus;
        dn_devfn   = tgt_q.devfn;
        dn_off     = tgt_q.off;
        dn_len     = 3'd0;
        dn_wdata   = wdata_q;
        unique case (state)
            ST_IDLE: begin
                cpu_rdy  = 1'b1;
                latch_wr = accept && !cpu_sel && cpu_we;
            end
            ST_PROBE: dn_req = 1'b1;
            ST_PROBE_F0: begin
                dn_req   = 1'b1;
                dn_devfn = {tgt_q.devfn[7:3], 3'd0};
            end
            ST_ACCESS: begin
                dn_req = 1'b1;
                dn_op  = we_q ? OP_WRITE : OP_READ;
                dn_len = len_q;
            end
            ST_RESP: begin
                cpu_rvalid = 1'b1;
                cpu_rdata  = rdata_q;
            end
            default: ;
        endcase
    end

    // R6: an outstanding request holds its fields until acknowledged
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_op) && $stable(dn_bus)
                                 && $stable(dn_devfn) && $stable(dn_off) && $stable(dn_len)));

    // R11: read data strobe lasts one cycle
    a_r11_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);

    // R10: hot-added function 0 goes straight to the access
    a_r10_fn0_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROBE && dn_ack && dn_found && dn_hotadd && !nonzero_fn)
            |=> (state == ST_ACCESS));

    // R7: a failed lookup never leads to an access request
    a_r7_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_op == OP_LOOKUP && dn_ack && !dn_found) |=> !(dn_req && dn_op != OP_LOOKUP));
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
    import cfgp_pkg::*;
#(
    parameter int unsigned SPACE_LIMIT = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    output logic        cpu_rdy,
    input  logic        cpu_we,
    input  logic        cpu_sel,
    input  logic [1:0]  cpu_addr,
    input  logic [2:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_rvalid,
    output logic [31:0] cpu_rdata,
    output logic        dn_req,
    output logic [1:0]  dn_op,
    output logic [7:0]  dn_bus,
    output logic [7:0]  dn_devfn,
    output logic [7:0]  dn_off,
    output logic [2:0]  dn_len,
    output logic [31:0] dn_wdata,
    input  logic        dn_ack,
    input  logic        dn_found,
    input  logic        dn_hotadd,
    input  logic [31:0] dn_rdata
);
    localparam int unsigned LIM_W = 9;
    localparam logic [LIM_W-1:0] LIM_V = LIM_W'(SPACE_LIMIT);

    logic [WORD_W-1:0] latch_q;
    logic              latch_wr;
    cfg_target_t       tgt;
    logic              enabled;
    logic              in_range;
    logic [2:0]        len;

    cfg_addr_latch #(.WIDTH(WORD_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (latch_wr),
        .wr_off  (cpu_addr),
        .wr_size (cpu_size),
        .wr_data (cpu_wdata),
        .q       (latch_q)
    );

    cfg_window_calc #(.SPACE_LIMIT(SPACE_LIMIT)) u_calc (
        .latch_q  (latch_q),
        .win_addr (cpu_addr),
        .req_size (cpu_size),
        .tgt      (tgt),
        .enabled  (enabled),
        .in_range (in_range),
        .len      (len)
    );

    cfg_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_sel    (cpu_sel),
        .cpu_wdata  (cpu_wdata),
        .latch_q    (latch_q),
        .tgt        (tgt),
        .enabled    (enabled),
        .in_range   (in_range),
        .len        (len),
        .cpu_rdy    (cpu_rdy),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .latch_wr   (latch_wr),
        .dn_req     (dn_req),
        .dn_op      (dn_op),
        .dn_bus     (dn_bus),
        .dn_devfn   (dn_devfn),
        .dn_off     (dn_off),
        .dn_len     (dn_len),
        .dn_wdata   (dn_wdata),
        .dn_ack     (dn_ack),
        .dn_found   (dn_found),
        .dn_hotadd  (dn_hotadd),
        .dn_rdata   (dn_rdata)
    );

    // R4: no downstream traffic unless the latched enable is set
    a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> latch_q[WORD_W-1]);

    // R8: downstream offsets always lie inside the space
    a_r8_in_space: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> ({1'b0, dn_off} < LIM_V));

    // R9: an access never runs past the space limit
    a_r9_clip: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_op != OP_LOOKUP) |-> (({1'b0, dn_off} + {6'd0, dn_len}) <= LIM_V
                                            && dn_len <= 3'd4 && dn_len != 3'd0));

    // R11: the block is not ready while traffic is outstanding
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> !cpu_rdy);
endmodule

// File: tb/sim_cfg_access_port.sv
module sim_cfg_access_port;
    localparam int LIM = 192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_sel = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic [2:0]  cpu_size = 3'd4;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rdy, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        dn_req;
    logic [1:0]  dn_op;
    logic [7:0]  dn_bus, dn_devfn, dn_off;
    logic [2:0]  dn_len;
    logic [31:0] dn_wdata;
    logic        dn_ack = 1'b0, dn_found = 1'b0, dn_hotadd = 1'b0;
    logic [31:0] dn_rdata = '0;

    always #10 clk = ~clk;

    cfg_access_port #(.SPACE_LIMIT(LIM)) u0 (.*);

    int total = 0, bad = 0;
    logic [31:0] exp_latch = '0;

    // downstream model state
    bit         pend = 0;
    int         wcnt = 0;
    logic [28:0] held;
    int         stable_bad = 0;
    int         n_lookup = 0, n_access = 0;
    logic [7:0] lk_devfn [4];
    logic [1:0] la_op;
    logic [7:0] la_bus, la_devfn, la_off;
    logic [2:0] la_len;
    logic [31:0] la_wdata;
    bit         busy_bad = 0;

    function automatic bit present(input logic [7:0] b, input logic [7:0] d);
        return ((int'(b) ^ (int'(d) * 3)) % 5) != 0;
    endfunction

    function automatic bit hot(input logic [7:0] b, input logic [7:0] d);
        return ((int'(d) + int'(b)) % 3) == 1;
    endfunction

    function automatic logic [31:0] mdata(input logic [7:0] b, input logic [7:0] d,
                                          input logic [7:0] o, input logic [2:0] n);
        logic [31:0] v, m;
        v = {b, d, o, 8'h5A} ^ 32'h9E37_79B9;
        m = (n >= 3'd4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * n)) - 32'd1);
        return v & m;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (dn_ack) begin
            dn_ack = 1'b0;
            pend = 0;
        end else if (dn_req) begin
            if (!pend) begin
                pend = 1;
                wcnt = $urandom % 3;
                held = {dn_op, dn_bus, dn_devfn, dn_off, dn_len};
            end else if (held != {dn_op, dn_bus, dn_devfn, dn_off, dn_len}) begin
                stable_bad++;
            end
            if (wcnt == 0) begin
                dn_ack = 1'b1;
                if (dn_op == 2'd0) begin
                    dn_found  = present(dn_bus, dn_devfn);
                    dn_hotadd = hot(dn_bus, dn_devfn);
                    if (n_lookup < 4) lk_devfn[n_lookup] = dn_devfn;
                    n_lookup++;
                    dn_rdata = 32'h0;
                end else begin
                    n_access++;
                    la_op = dn_op; la_bus = dn_bus; la_devfn = dn_devfn;
                    la_off = dn_off; la_len = dn_len; la_wdata = dn_wdata;
                    dn_rdata = (dn_op == 2'd1) ? mdata(dn_bus, dn_devfn, dn_off, dn_len) : 32'h0;
                end
            end else begin
                wcnt--;
            end
        end
    end

    task automatic cpu_op(input bit sel, input bit we, input logic [1:0] a,
                          input logic [2:0] sz, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        while (!cpu_rdy) @(negedge clk);
        cpu_req = 1'b1; cpu_sel = sel; cpu_we = we; cpu_addr = a;
        cpu_size = sz; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        lat = 1;
        rd = '0;
        if (we) begin
            while (!cpu_rdy) @(negedge clk);
        end else begin
            while (!cpu_rvalid) begin
                if (cpu_rdy) busy_bad = 1;
                @(negedge clk);
                lat++;
            end
            rd = cpu_rdata;
        end
    endtask

    task automatic set_latch(input logic [31:0] v);
        logic [31:0] rd;
        int lat;
        cpu_op(1'b0, 1'b1, 2'd0, 3'd4, v, rd, lat);
        exp_latch = v;
    endtask

    // one window access checked against the model
    task automatic run_data(input bit we, input logic [1:0] a, input logic [2:0] sz,
                            input logic [31:0] wd, input string tag);
        logic [31:0] eff, rd, erd;
        logic [7:0]  b, d, o, d0;
        logic [2:0]  want, elen;
        int          elk, eacc, lat, rem;
        eff = exp_latch | {30'd0, a};
        b = eff[23:16]; d = eff[15:8]; o = eff[7:0];
        d0 = {d[7:3], 3'd0};
        want = (sz > 3'd4) ? 3'd4 : sz;
        rem  = LIM - int'(o);
        elen = (rem < int'(want)) ? 3'(rem) : want;
        erd  = 32'hFFFF_FFFF;
        if (!exp_latch[31] || int'(o) >= LIM) begin
            elk = 0; eacc = 0;
        end else if (!present(b, d)) begin
            elk = 1; eacc = 0;
        end else if (hot(b, d) && d[2:0] != 3'd0) begin
            elk = 2; eacc = present(b, d0) ? 1 : 0;
        end else begin
            elk = 1; eacc = 1;
        end
        if (eacc == 1 && !we) erd = mdata(b, d, o, elen);
        n_lookup = 0; n_access = 0;
        cpu_op(1'b1, we, a, sz, wd, rd, lat);
        if (!we) chk(rd == erd, tag, "R4/R7/R11 read data", rd, erd);
        chk(n_lookup == elk, tag, "R6/R10 lookup count", n_lookup, elk);
        chk(n_access == eacc, tag, "R7/R8 access count", n_access, eacc);
        if (elk == 2)
            chk(lk_devfn[1] == d0, tag, "R10 fn0 lookup devfn", lk_devfn[1], d0);
        if (eacc == 1 && n_access == 1) begin
            chk({la_bus, la_devfn, la_off} == eff[23:0], tag, "R5 target",
                {8'd0, la_bus, la_devfn, la_off}, {8'd0, eff[23:0]});
            chk(la_len == elen, tag, "R9 length", la_len, elen);
            chk(la_op == (we ? 2'd2 : 2'd1), tag, "R6 op code", la_op, we ? 2'd2 : 2'd1);
            if (we) chk(la_wdata == wd, tag, "R6 write data", la_wdata, wd);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int lat;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cpu_rdy == 1'b1, "R1", "rdy after reset", cpu_rdy, 1);
        chk(dn_req == 1'b0 && cpu_rvalid == 1'b0, "R1", "idle outputs", {dn_req, cpu_rvalid}, 0);
        cpu_op(1'b0, 1'b0, 2'd0, 3'd4, 0, rd, lat);
        chk(rd == 32'h0, "R1", "latch after reset", rd, 0);

        // R4 disabled window after reset
        run_data(1'b0, 2'd0, 3'd4, 0, "R4");
        run_data(1'b1, 2'd1, 3'd2, 32'h1234, "R4");

        // R2 / R3 address port
        set_latch(32'h7F12_3456);
        cpu_op(1'b0, 1'b1, 2'd0, 3'd2, 32'hDEAD_BEEF, rd, lat);
        cpu_op(1'b0, 1'b1, 2'd1, 3'd4, 32'hDEAD_BEEF, rd, lat);
        cpu_op(1'b0, 1'b0, 2'd3, 3'd1, 0, rd, lat);
        chk(rd == 32'h7F12_3456, "R2/R3", "latch after partial writes", rd, 32'h7F12_3456);
        chk(lat == 1, "R3", "address read latency", lat, 1);
        cpu_op(1'b0, 1'b0, 2'd1, 3'd2, 0, rd, lat);
        chk(rd == 32'h7F12_3456, "R3", "narrow read full word", rd, 32'h7F12_3456);
        run_data(1'b0, 2'd0, 3'd4, 0, "R4");

        // R8 / R9 boundaries with merge of window bits (R5)
        set_latch(32'h8001_08C0);
        run_data(1'b0, 2'd0, 3'd4, 0, "R8");
        run_data(1'b1, 2'd2, 3'd4, 32'hAAAA, "R8");
        for (int dv = 8; dv < 64; dv += 8) begin
            if (present(8'd1, 8'(dv))) begin
                set_latch({8'h80, 8'd1, 8'(dv), 8'hBE});
                run_data(1'b0, 2'd0, 3'd4, 0, "R9");
                set_latch({8'h80, 8'd1, 8'(dv), 8'hBC});
                run_data(1'b0, 2'd3, 3'd4, 0, "R5/R9");
                run_data(1'b1, 2'd1, 3'd2, 32'h55AA, "R5/R9");
                break;
            end
        end

        // R10 hidden and visible hot-added functions, R7 absent
        for (int dv = 1; dv < 256; dv++) begin
            set_latch({8'h80, 8'd2, 8'(dv), 8'h10});
            run_data(1'b0, 2'd0, 3'd4, 0, "R10");
            if (dv > 40) break;
        end

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [2:0] sz;
            if (($urandom % 4) == 0) begin
                logic [31:0] v;
                v = $urandom;
                v[31] = (($urandom % 8) != 0);
                v[23:16] = 8'($urandom % 4);
                set_latch(v);
            end
            case ($urandom % 3)
                0: sz = 3'd1;
                1: sz = 3'd2;
                default: sz = 3'd4;
            endcase
            run_data(1'($urandom % 2), 2'($urandom), sz, $urandom, "random");
        end

        chk(stable_bad == 0, "R6", "request held until ack", stable_bad, 0);
        chk(busy_bad == 0, "R11", "rdy low while busy", busy_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule